// File: doc/BRIEF.md
# Script Register-Operation Unit

This block carries out the byte-wide register instructions of a script-driven controller. Each instruction names one byte of a small, byte-addressed register file, an operation and an 8-bit immediate. One byte of the file is reserved as the first-byte register. It acts as an accumulator: an instruction may read it as the source and write the named byte, read the named byte and write the result into it, or read and write the named byte with no accumulator at all.

A single carry flag is kept next to the arithmetic. Both shifts and both adds update it, and it feeds the add-with-carry and the shift-in bit. The flag is exposed so that branch logic outside the block can test it. The block accepts one instruction per cycle. One cycle later it answers with a done pulse, the byte it wrote and an illegal flag. A combinational read port lets the surrounding logic look at any byte of the file.

Top module: `regop_unit`

## Requirements
- R1: After reset every register byte reads 0x00, carry is 0, and done and illegal are 0.
- R2: Instruction bits 31:27 = 5'b01101 write the register at offset bits 23:16 with (first-byte register op immediate). The first-byte register lives at offset 0x08 and is left unchanged unless it is itself the target.
- R3: Bits 31:27 = 5'b01110 write the first-byte register (offset 0x08) with (register at the offset op immediate). The register at the offset is left unchanged.
- R4: Bits 31:27 = 5'b01111 write the register at the offset with (its own value op immediate).
- R5: Bits 26:24 select the operation: 0 load immediate, 2 OR, 3 XOR and 4 AND. The immediate is in bits 15:8.
- R6: Operation 1 (shift left) gives {src[6:0], carry} and sets carry to src[7]. Operation 5 (shift right) gives {carry, src[7:1]} and sets carry to src[0].
- R7: Operation 6 gives src + imm and operation 7 gives src + imm + carry. Each sets carry to the carry out of bit 7.
- R8: Load, OR, XOR and AND leave carry unchanged.
- R9: An instruction strobed at a clock edge raises done for exactly the following cycle. Result then shows the byte written, and the file already holds it. Back-to-back strobes give back-to-back done pulses.
- R10: An instruction is illegal if the second word is nonzero, if bits 31:27 are none of the three codes, or if the offset is 0x60 or above. An illegal instruction gives done with illegal=1 and result 0x00, and it changes no register and not the carry.
- R11: The read port returns the byte at rd_addr within the same cycle, and returns 0x00 for addresses 0x60 to 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Strobe: instruction present this cycle |
| instr_word | input | 32 | First instruction word (class, operation, offset, immediate) |
| operand_word | input | 32 | Second instruction word, must be zero |
| rd_addr | input | 7 | Read-port byte address |
| rd_data | output | 8 | Read-port data |
| done | output | 1 | Completion pulse, one cycle after the strobe |
| illegal | output | 1 | Completed instruction was rejected |
| result | output | 8 | Byte written by the completed instruction |
| carry | output | 1 | Current carry flag |

## Verification
A bad carry shows up at the carry port in the cycle after the instruction that produced it. Because the next shift or add-with-carry consumes the flag, the error then also spreads into that instruction's result. A wrong source or destination choice in the data-flow decode shows in the same cycle as the done pulse, either as an unexpected result or as a byte that changed when it should not have, which a read of both the named byte and the first-byte register exposes. An illegal instruction that still writes leaves a changed byte that stays visible through the read port until it is overwritten.

// File: rtl/regop_pkg.sv
package regop_pkg;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_SHL  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_AND  = 3'd4,
        OP_SHR  = 3'd5,
        OP_ADD  = 3'd6,
        OP_ADDC = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        FLOW_NONE    = 2'd0,
        FLOW_FROM_FB = 2'd1,
        FLOW_TO_FB   = 2'd2,
        FLOW_SELF    = 2'd3
    } flow_e;

    localparam logic [4:0] CLS_FROM_FB = 5'b01101;
    localparam logic [4:0] CLS_TO_FB   = 5'b01110;
    localparam logic [4:0] CLS_SELF    = 5'b01111;

    typedef struct packed {
        flow_e      flow;
        alu_op_e    op;
        logic [7:0] offset;
        logic [7:0] imm;
        logic       legal;
        logic       carry_op;
    } dec_t;

    typedef struct packed {
        logic       done;
        logic       illegal;
        logic [7:0] result;
        logic       carry;
    } unit_st_t;

endpackage

// File: rtl/regop_decode.sv
module regop_decode
    import regop_pkg::*;
#(
    parameter int REG_BYTES = 96
) (
    input  logic [31:0] instr_word,
    input  logic [31:0] operand_word,
    output dec_t        dec
);

    logic [4:0] cls;

    always_comb begin
        cls        = instr_word[31:27];
        dec.op     = alu_op_e'(instr_word[26:24]);
        dec.offset = instr_word[23:16];
        dec.imm    = instr_word[15:8];

        unique case (cls)
            CLS_FROM_FB: dec.flow = FLOW_FROM_FB;
            CLS_TO_FB:   dec.flow = FLOW_TO_FB;
            CLS_SELF:    dec.flow = FLOW_SELF;
            default:     dec.flow = FLOW_NONE;
        endcase

        dec.legal = (dec.flow != FLOW_NONE)
                 && (operand_word == 32'd0)
                 && ({24'd0, dec.offset} < 32'(REG_BYTES));

        dec.carry_op = (dec.op == OP_SHL) || (dec.op == OP_SHR)
                    || (dec.op == OP_ADD) || (dec.op == OP_ADDC);
    end

endmodule

// File: rtl/regop_alu.sv
module regop_alu
    import regop_pkg::*;
(
    input  alu_op_e    op,
    input  logic [7:0] src,
    input  logic [7:0] imm,
    input  logic       cin,
    output logic [7:0] res,
    output logic       cout
);

    logic [8:0] sum9;
    logic       add_cin;

    always_comb begin
        add_cin = (op == OP_ADDC) ? cin : 1'b0;
        sum9    = {1'b0, src} + {1'b0, imm} + {8'd0, add_cin};
        cout    = cin;
        unique case (op)
            OP_LOAD: res = imm;
            OP_SHL: begin
                res  = {src[6:0], cin};
                cout = src[7];
            end
            OP_OR:  res = src | imm;
            OP_XOR: res = src ^ imm;
            OP_AND: res = src & imm;
            OP_SHR: begin
                res  = {cin, src[7:1]};
                cout = src[0];
            end
            OP_ADD, OP_ADDC: begin
                res  = sum9[7:0];
                cout = sum9[8];
            end
            default: res = imm;
        endcase
    end

endmodule

// File: rtl/regop_regfile.sv
module regop_regfile #(
    parameter int REG_BYTES = 96,
    localparam int ADDR_W   = $clog2(REG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);

    logic [7:0] regs_d [REG_BYTES];
    logic [7:0] regs_q [REG_BYTES];

    always_comb begin
        for (int i = 0; i < REG_BYTES; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (32'(waddr) < 32'(REG_BYTES))) begin
            regs_d[waddr] = wdata;
        end
        rdata_a = (32'(raddr_a) < 32'(REG_BYTES)) ? regs_q[raddr_a] : 8'h00;
        rdata_b = (32'(raddr_b) < 32'(REG_BYTES)) ? regs_q[raddr_b] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_BYTES; i++) begin
                regs_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < REG_BYTES; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    // The written byte appears on the read port in the following cycle.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (32'(waddr) < 32'(REG_BYTES)) && (raddr_b == waddr))
            |=> (rdata_b == $past(wdata)) || !$stable(raddr_b));

endmodule

// File: rtl/regop_unit.sv
module regop_unit
    import regop_pkg::*;
#(
    parameter int REG_BYTES = 96,
    parameter int FB_OFFSET = 8,
    localparam int ADDR_W   = $clog2(REG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic [31:0]       operand_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              illegal,
    output logic [7:0]        result,
    output logic              carry
);

    localparam logic [ADDR_W-1:0] FB_ADDR = ADDR_W'(FB_OFFSET);

    dec_t              dec;
    unit_st_t          st_d, st_q;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [7:0]        src_byte, alu_res;
    logic              alu_cout, wr_en;

    regop_decode #(.REG_BYTES(REG_BYTES)) u_dec (
        .instr_word   (instr_word),
        .operand_word (operand_word),
        .dec          (dec)
    );

    regop_alu u_alu (
        .op   (dec.op),
        .src  (src_byte),
        .imm  (dec.imm),
        .cin  (st_q.carry),
        .res  (alu_res),
        .cout (alu_cout)
    );

    regop_regfile #(.REG_BYTES(REG_BYTES)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (dst_addr),
        .wdata   (alu_res),
        .raddr_a (src_addr),
        .rdata_a (src_byte),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );

    always_comb begin
        src_addr = (dec.flow == FLOW_FROM_FB) ? FB_ADDR : dec.offset[ADDR_W-1:0];
        dst_addr = (dec.flow == FLOW_TO_FB)   ? FB_ADDR : dec.offset[ADDR_W-1:0];
        wr_en    = instr_valid && dec.legal;

        st_d         = st_q;
        st_d.done    = instr_valid;
        st_d.illegal = instr_valid && !dec.legal;
        if (wr_en) begin
            st_d.result = alu_res;
            if (dec.carry_op) begin
                st_d.carry = alu_cout;
            end
        end else if (instr_valid) begin
            st_d.result = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign illegal = st_q.illegal;
    assign result  = st_q.result;
    assign carry   = st_q.carry;

    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> done);

    assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !done);

    assert_carry_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && dec.legal && dec.carry_op) |=> $stable(carry));

    assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && result == 8'h00));

endmodule

// File: tb/regop_unit_test.sv
module regop_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] operand_word = '0;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        done, illegal, carry;
    logic [7:0]  result;

    int checks = 0;
    int failures = 0;
    int pops = 0;
    int pushes = 0;
    bit finished = 0;

    logic [7:0] mdl_regs [NREG];
    logic       mdl_carry = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic       ill;
        logic       cy;
        string      tag;
    } exp_t;
    exp_t scb[$];

    regop_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr_word   (instr_word),
        .operand_word (operand_word),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .done         (done),
        .illegal      (illegal),
        .result       (result),
        .carry        (carry)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(logic [4:0] cls, logic [2:0] op,
                                       logic [7:0] off, logic [7:0] imm);
        return {cls, op, off, imm, 8'h00};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: model the instruction, push expectation, drive for one cycle.
    task automatic issue(logic [31:0] iw, logic [31:0] ow, string tag);
        logic [4:0] cls;
        logic [2:0] op;
        logic [7:0] off, imm, src, r;
        logic       nc, legal;
        int         dst;
        exp_t       e;
        cls = iw[31:27]; op = iw[26:24]; off = iw[23:16]; imm = iw[15:8];
        legal = (ow == 0) && (cls inside {5'b01101, 5'b01110, 5'b01111}) && (off < 8'd96);
        nc = mdl_carry;
        r = 8'h00;
        if (legal) begin
            src = (cls == 5'b01101) ? mdl_regs[8] : mdl_regs[off];
            dst = (cls == 5'b01110) ? 8 : int'(off);
            case (op)
                3'd0: r = imm;
                3'd1: begin r = {src[6:0], mdl_carry}; nc = src[7]; end
                3'd2: r = src | imm;
                3'd3: r = src ^ imm;
                3'd4: r = src & imm;
                3'd5: begin r = {mdl_carry, src[7:1]}; nc = src[0]; end
                3'd6: {nc, r} = {1'b0, src} + {1'b0, imm};
                default: {nc, r} = {1'b0, src} + {1'b0, imm} + {8'd0, mdl_carry};
            endcase
            mdl_regs[dst] = r;
            mdl_carry = nc;
        end
        e.res = r; e.ill = !legal; e.cy = mdl_carry; e.tag = tag;
        scb.push_back(e);
        pushes++;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word = iw;
        operand_word = ow;
    endtask

    task automatic idle();
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word = '0;
        operand_word = '0;
        @(negedge clk);
        chk("R9", {31'd0, done}, 32'd0, "done after idle");
    endtask

    task automatic check_reg(int addr, string tag);
        rd_addr = 7'(addr);
        #1;
        chk(tag, {24'd0, rd_data}, {24'd0, mdl_regs[addr]}, $sformatf("reg[%0h]", addr));
    endtask

    // Monitor: compare each completion with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (scb.size() == 0) begin
                chk("R9", 32'd1, 32'd0, "unexpected done");
            end else begin
                exp_t e;
                e = scb.pop_front();
                pops++;
                chk(e.tag, {24'd0, result}, {24'd0, e.res}, "result");
                chk(e.tag, {31'd0, illegal}, {31'd0, e.ill}, "illegal");
                chk(e.tag, {31'd0, carry}, {31'd0, e.cy}, "carry");
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NREG; i++) mdl_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, done}, 32'd0, "done");
        chk("R1", {31'd0, illegal}, 32'd0, "illegal");
        chk("R1", {31'd0, carry}, 32'd0, "carry");
        check_reg(8'h00, "R1");
        check_reg(8'h08, "R1");
        check_reg(8'h5F, "R1");

        // R4/R5 self flow with load and logic ops
        issue(mk(5'b01111, 3'd0, 8'h10, 8'hA5), 0, "R5_load");
        issue(mk(5'b01111, 3'd2, 8'h10, 8'h0A), 0, "R5_or");
        issue(mk(5'b01111, 3'd3, 8'h10, 8'hFF), 0, "R5_xor");
        issue(mk(5'b01111, 3'd4, 8'h10, 8'h3C), 0, "R4_and");
        idle();
        check_reg(8'h10, "R4");

        // R2 first-byte register as source
        issue(mk(5'b01111, 3'd0, 8'h08, 8'h3C), 0, "R2_setfb");
        issue(mk(5'b01101, 3'd2, 8'h20, 8'h01), 0, "R2_or");
        issue(mk(5'b01101, 3'd0, 8'h07, 8'h99), 0, "R2_load");
        idle();
        check_reg(8'h20, "R2");
        check_reg(8'h07, "R2");
        check_reg(8'h08, "R2");

        // R3 first-byte register as destination
        issue(mk(5'b01110, 3'd3, 8'h10, 8'hFF), 0, "R3_xor");
        issue(mk(5'b01110, 3'd2, 8'h20, 8'h00), 0, "R3_move");
        idle();
        check_reg(8'h08, "R3");
        check_reg(8'h10, "R3");
        check_reg(8'h20, "R3");

        // R6 shifts through carry
        issue(mk(5'b01111, 3'd0, 8'h11, 8'h81), 0, "R6_setup");
        issue(mk(5'b01111, 3'd1, 8'h11, 8'h00), 0, "R6_shl1");
        issue(mk(5'b01111, 3'd1, 8'h11, 8'h00), 0, "R6_shl2");
        issue(mk(5'b01111, 3'd0, 8'h12, 8'h03), 0, "R6_setup2");
        issue(mk(5'b01111, 3'd5, 8'h12, 8'h00), 0, "R6_shr1");
        issue(mk(5'b01111, 3'd5, 8'h12, 8'h00), 0, "R6_shr2");
        idle();
        check_reg(8'h11, "R6");
        check_reg(8'h12, "R6");

        // R7 add and add-with-carry
        issue(mk(5'b01111, 3'd0, 8'h13, 8'hF0), 0, "R7_setup");
        issue(mk(5'b01111, 3'd6, 8'h13, 8'h20), 0, "R7_add_ovf");
        issue(mk(5'b01111, 3'd7, 8'h13, 8'h00), 0, "R7_addc");
        issue(mk(5'b01111, 3'd0, 8'h14, 8'h7F), 0, "R7_setup2");
        issue(mk(5'b01111, 3'd6, 8'h14, 8'h01), 0, "R7_add");
        issue(mk(5'b01111, 3'd6, 8'h14, 8'hFF), 0, "R7_add_ovf2");
        issue(mk(5'b01111, 3'd7, 8'h14, 8'h10), 0, "R7_addc_cin");
        idle();
        check_reg(8'h14, "R7");

        // R8 carry held by non-carry ops (carry is 1 here)
        issue(mk(5'b01111, 3'd6, 8'h15, 8'hFF), 0, "R8_setc");
        issue(mk(5'b01111, 3'd6, 8'h15, 8'h01), 0, "R8_setc2");
        issue(mk(5'b01111, 3'd0, 8'h15, 8'h00), 0, "R8_load");
        issue(mk(5'b01111, 3'd2, 8'h15, 8'hF0), 0, "R8_or");
        issue(mk(5'b01111, 3'd3, 8'h15, 8'h0F), 0, "R8_xor");
        issue(mk(5'b01111, 3'd4, 8'h15, 8'h00), 0, "R8_and");
        idle();
        chk("R8", {31'd0, carry}, {31'd0, mdl_carry}, "carry held");

        // R10 illegal forms
        issue(mk(5'b01111, 3'd0, 8'h10, 8'h55), 32'h0000_0001, "R10_operand");
        issue(mk(5'b10000, 3'd0, 8'h10, 8'h55), 0, "R10_class");
        issue(mk(5'b01111, 3'd6, 8'h60, 8'hFF), 0, "R10_range");
        issue(mk(5'b01110, 3'd1, 8'h10, 8'h00), 32'h8000_0000, "R10_tofb");
        idle();
        check_reg(8'h10, "R10");
        check_reg(8'h08, "R10");
        chk("R10", {31'd0, carry}, {31'd0, mdl_carry}, "carry after illegal");

        // R11 read port beyond the map
        rd_addr = 7'h70;
        #1;
        chk("R11", {24'd0, rd_data}, 32'd0, "out of range read");
        check_reg(8'h5F, "R11");

        // R9 all expectations consumed
        chk("R9", 32'(pops), 32'(pushes), "done count");
        finish_run();
    end

endmodule